// File: doc/BRIEF.md
# Self-Synchronizing Serial Scrambler Lane

This block is one serial lane that either scrambles or descrambles a bit stream with the polynomial 1 + x^-18 + x^-23. In scramble mode it divides the incoming data by the polynomial: each output bit is the data bit XORed with two of the lane's own earlier output bits, so the history register holds what was sent. In descramble mode it multiplies by the same polynomial: the history register holds received channel bits, and each output bit is the received bit XORed with two of the earlier received bits. The two transfer functions are exact inverses, so a scrambler lane feeding a descrambler lane returns the original data.

Neither side needs a sync word or a shared seed. The descrambler's history fills with channel bits, so after 23 correct received bits its output is correct, whatever state it started in. Long constant runs at the input, such as idle fill, leave the scrambler as well-mixed output with frequent transitions, which helps the receiver recover its clock. The cost is error multiplication: one bad channel bit corrupts three recovered bits.

Two instances are used in a link: one with the mode input tied to scramble at the sender and one tied to descramble at the receiver. Bits move one per cycle in which the input valid is high, and the result comes out in that same cycle.

Top module: `ssc_lane`

## Requirements
- R1: With mode = 0 (scramble), on each valid cycle n, out_bit = in_bit XOR s[n-18] XOR s[n-23]. Here s[k] is the lane's own output on the k-th valid cycle since reset, and the terms before the first valid cycle are 0.
- R2: With mode = 1 (descramble), on each valid cycle n, out_bit = in_bit XOR r[n-18] XOR r[n-23]. Here r[k] is the input bit on the k-th valid cycle since reset, and the terms before the first valid cycle are 0.
- R3: A scrambler lane whose output drives a descrambler lane, both reset together, returns every input bit unchanged and in the same cycle.
- R4: When the descrambler starts from a history that does not match the scrambler's, its output equals the original data from the 24th valid bit on (index 23 counting from 0).
- R5: With both lanes reset together, inverting a single channel bit at valid index k corrupts exactly the recovered bits at indices k, k+18 and k+23, and no others.
- R6: Synchronous reset clears the history to all zeros. After reset, the first 18 valid outputs equal their inputs in either mode, and an all-zero input stream gives all-zero output.
- R7: out_valid equals in_valid in the same cycle. A cycle with in_valid low does not advance the history, so later outputs are the same as if that cycle had been left out.
- R8: Starting from reset, a run of 256 consecutive one bits into the scrambler gives an output with at least 32 transitions between adjacent bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the history |
| mode | input | 1 | 0 = scramble (divide), 1 = descramble (multiply) |
| in_valid | input | 1 | Input bit is present this cycle |
| in_bit | input | 1 | Serial data or channel bit |
| out_valid | output | 1 | Output bit is present this cycle (same cycle as in_valid) |
| out_bit | output | 1 | Scrambled or recovered bit |

## Verification
A scrambler lane and a descrambler lane are chained, and random data with irregular valid gaps runs through them. This separates correct tap positions and feedback sources from an off-by-one delay, and it shows whether idle cycles wrongly advance the history. Restarting only the scrambler while the descrambler keeps stale history shows that recovery follows the channel alone within 23 bits. One flipped channel bit gives the exact corruption pattern at offsets 0, 18 and 23, which exposes a wrong tap. An all-ones run from reset and a run of zeros from reset show the mixing on constant input and the reset state.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic {
    SSC_SCRAMBLE   = 1'b0,
    SSC_DESCRAMBLE = 1'b1
  } ssc_mode_e;

  // Polynomial combination of the current bit and the two tapped history bits.
  function automatic logic ssc_mix(input logic cur, input logic near_tap, input logic far_tap);
    return cur ^ near_tap ^ far_tap;
  endfunction

  // Bit that enters the history: own output (divide) or the received bit (multiply).
  function automatic logic ssc_feed(input ssc_mode_e m, input logic cur, input logic result);
    return (m == SSC_DESCRAMBLE) ? cur : result;
  endfunction

endpackage

// File: rtl/ssc_delay_line.sv
module ssc_delay_line #(
  parameter int DEPTH = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             shift_in,
  output logic [DEPTH-1:0] taps
);

  // taps[0] holds the bit delayed by one valid cycle, taps[k] the bit delayed by k+1.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)           taps[i] <= 1'b0;
        else if (shift_en) taps[i] <= shift_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)           taps[i] <= 1'b0;
        else if (shift_en) taps[i] <= taps[i-1];
      end
    end
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(taps));

  // R7
  advance_one_stage_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> taps[DEPTH-1:1] == $past(taps[DEPTH-2:0]));

endmodule

// File: rtl/ssc_tap_mixer.sv
module ssc_tap_mixer
  import ssc_pkg::*;
(
  input  ssc_mode_e mode,
  input  logic      cur_bit,
  input  logic      near_bit,
  input  logic      far_bit,
  output logic      result_bit,
  output logic      feed_bit
);

  always_comb begin
    result_bit = ssc_mix(cur_bit, near_bit, far_bit);
    feed_bit   = ssc_feed(mode, cur_bit, result_bit);
  end

endmodule

// File: rtl/ssc_lane.sv
module ssc_lane
  import ssc_pkg::*;
#(
  parameter int TAP_NEAR = 18,
  parameter int TAP_FAR  = 23
) (
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic in_valid,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit
);

  localparam int HIST_W   = TAP_FAR;
  localparam int NEAR_IDX = TAP_NEAR - 1;
  localparam int FAR_IDX  = TAP_FAR - 1;

  ssc_mode_e        lane_mode;
  logic [HIST_W-1:0] hist;
  logic             near_bit;
  logic             far_bit;
  logic             feed_bit;
  logic             result_bit;

  assign lane_mode = ssc_mode_e'(mode);
  assign near_bit  = hist[NEAR_IDX];
  assign far_bit   = hist[FAR_IDX];

  ssc_tap_mixer u_mixer (
    .mode       (lane_mode),
    .cur_bit    (in_bit),
    .near_bit   (near_bit),
    .far_bit    (far_bit),
    .result_bit (result_bit),
    .feed_bit   (feed_bit)
  );

  ssc_delay_line #(.DEPTH(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (in_valid),
    .shift_in (feed_bit),
    .taps     (hist)
  );

  assign out_valid = in_valid;
  assign out_bit   = result_bit;

  // R6
  reset_clears_hist_chk: assert property (@(posedge clk)
    rst |=> hist == '0);

  // R1
  divide_feeds_output_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_mode == SSC_SCRAMBLE) |=> hist[0] == $past(out_bit));

  // R2
  multiply_feeds_input_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_mode == SSC_DESCRAMBLE) |=> hist[0] == $past(in_bit));

endmodule

// File: tb/tb_ssc_lane.sv
module tb_ssc_lane;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_tx, rst_rx;
  logic in_valid, in_bit, flip;
  logic tx_valid, tx_bit, rx_valid, rx_bit, ch_bit;

  assign ch_bit = tx_bit ^ flip;

  ssc_lane dut (
    .clk(clk), .rst(rst_tx), .mode(1'b0),
    .in_valid(in_valid), .in_bit(in_bit),
    .out_valid(tx_valid), .out_bit(tx_bit)
  );

  ssc_lane dut_rx (
    .clk(clk), .rst(rst_rx), .mode(1'b1),
    .in_valid(tx_valid), .in_bit(ch_bit),
    .out_valid(rx_valid), .out_bit(rx_bit)
  );

  typedef struct {
    logic  v;
    logic  etx;
    logic  erx;
    bit    ctx;
    bit    crx;
    string ttx;
    string trx;
  } item_t;

  item_t sb[$];
  item_t it;
  int total = 0;
  int bad = 0;
  bit done = 0;

  // Independent model: newest bit at index 22, delay k lives at index 23-k.
  logic [22:0] m_tx, m_rx;

  bit   cnt_en = 0;
  bit   have_prev = 0;
  logic prev_tx;
  int   trans = 0;

  task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input bit tx, input bit rx);
    @(negedge clk);
    in_valid = 1'b0; in_bit = 1'b0; flip = 1'b0;
    rst_tx = tx; rst_rx = rx;
    @(negedge clk);
    rst_tx = 1'b0; rst_rx = 1'b0;
    if (tx) m_tx = '0;
    if (rx) m_rx = '0;
  endtask

  task automatic send(input logic v, input logic d, input logic fl,
                      input bit ctx, input bit crx, input bit rx_model, input logic rx_target,
                      input string ttx, input string trx);
    item_t x;
    logic t_out, ch, r_out;
    @(negedge clk);
    in_valid = v; in_bit = d; flip = fl;
    x.v = v; x.ctx = ctx; x.crx = crx; x.ttx = ttx; x.trx = trx;
    x.etx = 1'b0; x.erx = 1'b0;
    if (v) begin
      t_out = d ^ m_tx[5] ^ m_tx[0];
      m_tx  = {t_out, m_tx[22:1]};
      ch    = t_out ^ fl;
      r_out = ch ^ m_rx[5] ^ m_rx[0];
      m_rx  = {ch, m_rx[22:1]};
      x.etx = t_out;
      x.erx = rx_model ? r_out : rx_target;
    end
    sb.push_back(x);
  endtask

  // Monitor: sample 2 ns after the falling edge, when inputs have settled.
  always @(negedge clk) begin
    #2;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      chk(tx_valid === it.v, "R7 tx out_valid", tx_valid, it.v);
      chk(rx_valid === it.v, "R7 rx out_valid", rx_valid, it.v);
      if (it.v && it.ctx) chk(tx_bit === it.etx, it.ttx, tx_bit, it.etx);
      if (it.v && it.crx) chk(rx_bit === it.erx, it.trx, rx_bit, it.erx);
      if (it.v && cnt_en) begin
        if (have_prev && tx_bit !== prev_tx) trans++;
        prev_tx = tx_bit;
        have_prev = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic d;
    rst_tx = 1'b1; rst_rx = 1'b1; in_valid = 1'b0; in_bit = 1'b0; flip = 1'b0;
    m_tx = '0; m_rx = '0;
    repeat (3) @(posedge clk);
    do_reset(1, 1);

    // R6: first 18 valid outputs equal inputs
    for (int i = 0; i < 18; i++) begin
      d = 1'($urandom);
      send(1, d, 0, 1, 1, 0, d, "R6 tx passthrough", "R6 rx passthrough");
    end
    // R6: zeros from reset stay zero
    do_reset(1, 1);
    for (int i = 0; i < 40; i++)
      send(1, 0, 0, 1, 1, 0, 1'b0, "R6 tx zero", "R6 rx zero");

    // R1 R2 R3 R7: random data with valid gaps
    do_reset(1, 1);
    for (int i = 0; i < 300; i++) begin
      if (($urandom % 4) == 0)
        send(0, 1'($urandom), 0, 0, 0, 1, 1'b0, "R7", "R7");
      else begin
        d = 1'($urandom);
        if (i % 2 == 0) send(1, d, 0, 1, 1, 1, 1'b0, "R1 scramble", "R2 descramble");
        else            send(1, d, 0, 1, 1, 0, d, "R1 scramble", "R3 round trip");
      end
    end

    // R4: restart only the scrambler; descrambler keeps stale history
    do_reset(1, 0);
    for (int i = 0; i < 80; i++) begin
      d = 1'($urandom);
      send(1, d, 0, 1, (i >= 23), 0, d, "R1 scramble", "R4 resync");
    end

    // R5: single channel error at index 40
    do_reset(1, 1);
    for (int i = 0; i < 100; i++) begin
      d = 1'($urandom);
      send(1, d, (i == 40), 1, 1, 0, d ^ ((i == 40) || (i == 58) || (i == 63)),
           "R1 scramble", "R5 error spread");
    end

    // R8: ones run from reset
    do_reset(1, 1);
    @(negedge clk);
    cnt_en = 1; have_prev = 0; trans = 0;
    for (int i = 0; i < 256; i++)
      send(1, 1, 0, 1, 1, 0, 1'b1, "R1 ones run", "R3 ones run");
    @(negedge clk);
    in_valid = 1'b0;
    #4;
    cnt_en = 0;
    total++;
    if (trans < 32) begin
      bad++;
      $display("FAIL R8 transitions actual=%0d expected>=32", trans);
    end

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule